// File: doc/BRIEF.md
# Single-Wire Start-Bit Serial Receiver

This block receives words from a single serial line that rests low between frames. A frame is one high start bit, then the data bits least significant bit first, then one low stop bit. A low-to-high change on the line, seen while the receiver is idle, sets a starter flag and opens a sampling window. The receiver then takes one sample per bit period from an oversampling clock. A one-hot ring counter marks the last data bit. When the ring counter returns home, the starter clears and the finished word goes into a small output buffer. The receiver is ready for the next start edge on the following cycle.

The line is asynchronous to the receiver clock. It passes through a synchronizer before any decision is made. The sampling clock runs at OSR times the nominal bit rate. The first data sample falls about one and a half bit periods after the start edge, and each later sample follows one bit period after the one before. Downstream logic reads words from the buffer with a show-ahead pop interface. A one-cycle pulse marks each word written. A sticky flag records any word lost to a full buffer.

Top module: `serline_rx`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `empty_o` is 1 and `full_o`, `ovf_o` and `wr_pulse_o` are 0.
- R2: Reception starts only on a low-to-high change of the line while idle. A line that stays high after the word it started yields exactly one word (all ones for DATA_W = 8) and no more.
- R3: A frame is a high start bit, DATA_W data bits least significant first, then a low stop bit. The received word equals the transmitted data bits, with the first data bit at bit 0.
- R4: With the defaults DATA_W = 8 and OSR = 16, words are received correctly when the transmitter bit period is anywhere from 0.95 to 1.05 times OSR receiver clocks.
- R5: Every completed frame gives exactly one `wr_pulse_o` pulse, which lasts a single cycle.
- R6: A frame whose start bit follows the previous stop bit with no idle gap is received correctly.
- R7: Rising edges inside a frame's data bits do not start extra frames. The number of words equals the number of frames sent.
- R8: The output buffer holds DEPTH (16) words and returns them in arrival order. `full_o` is 1 when it holds DEPTH words, and `full_o` and `empty_o` are never both 1.
- R9: A word completed while the buffer is full and no pop is requested is dropped. The stored contents stay unchanged, `ovf_o` goes to 1, and `ovf_o` stays 1 until reset.
- R10: A word completed in the same cycle as a pop on a full buffer is stored. The buffer stays full and `ovf_o` does not change.
- R11: A pop request while the buffer is empty has no effect. The buffer stays empty and later words are stored normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, OSR cycles per nominal bit |
| rst_n | input | 1 | Active-low reset |
| line_i | input | 1 | Asynchronous serial line, low when idle |
| rd_i | input | 1 | Pop the head word from the output buffer |
| rd_data_o | output | DATA_W | Head word of the output buffer (show-ahead) |
| empty_o | output | 1 | Output buffer holds no word |
| full_o | output | 1 | Output buffer holds DEPTH words |
| wr_pulse_o | output | 1 | One-cycle pulse, a word goes into the buffer on the next edge |
| ovf_o | output | 1 | Sticky flag, a word was lost to a full buffer |

## Verification
The cycle that needs care is the one where a finished word enters the buffer at the same clock edge as a pop of the head, while the buffer is full. The bench fills all sixteen entries and then sends one more frame. It watches `wr_pulse_o` on the falling edge and raises `rd_i` for exactly that cycle, so the push and the pop land on the same edge. It then expects the buffer still full, the overflow flag still clear, and the old second word at the head. A further frame with no pop must then set the flag and leave the sixteen stored words, checked in order, unchanged.

// File: rtl/serline_rx_pkg.sv
package serline_rx_pkg;

    // State of the frame starter flag
    typedef enum logic {
        STARTER_IDLE = 1'b0,
        STARTER_RUN  = 1'b1
    } starter_e;

endpackage

// File: rtl/serline_rx_sync.sv
// Brings the asynchronous line into the clock domain and flags a rising edge.
module serline_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_s_o,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.pipe = {s_q.pipe[STAGES-2:0], line_i};
        s_d.prev = s_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign line_s_o = s_q.pipe[STAGES-1];
    assign rise_o   = s_q.pipe[STAGES-1] & ~s_q.prev;

endmodule

// File: rtl/serline_rx_frame.sv
// Starter flag, bit-period timer, one-hot ring counter and shift register.
module serline_rx_frame
    import serline_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_s_i,
    input  logic              rise_i,
    output logic              wr_o,
    output logic [DATA_W-1:0] word_o
);

    // Cycles from the detected start edge to the first data sample
    localparam int FIRST_WAIT = OSR + OSR / 2 - 1;
    localparam int CNT_W      = $clog2(FIRST_WAIT + 1);
    localparam logic [CNT_W-1:0]  FIRST_LOAD = CNT_W'(FIRST_WAIT - 1);
    localparam logic [CNT_W-1:0]  BIT_LOAD   = CNT_W'(OSR - 1);
    localparam logic [DATA_W-1:0] RING_HOME  = DATA_W'(1);

    typedef struct packed {
        starter_e          starter;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] ring;
        logic [DATA_W-1:0] shreg;
        logic              wr;
        logic [DATA_W-1:0] word;
    } frm_t;

    frm_t f_d, f_q;
    logic [DATA_W-1:0] ring_nx;
    logic [DATA_W-1:0] sh_nx;

    always_comb begin
        f_d     = f_q;
        f_d.wr  = 1'b0;
        ring_nx = {f_q.ring[0], f_q.ring[DATA_W-1:1]};
        sh_nx   = {line_s_i, f_q.shreg[DATA_W-1:1]};
        case (f_q.starter)
            STARTER_IDLE: begin
                if (rise_i) begin
                    f_d.starter = STARTER_RUN;
                    f_d.cnt     = FIRST_LOAD;
                end
            end
            STARTER_RUN: begin
                if (f_q.cnt == '0) begin
                    f_d.cnt   = BIT_LOAD;
                    f_d.ring  = ring_nx;
                    f_d.shreg = sh_nx;
                    if (ring_nx[0]) begin
                        f_d.starter = STARTER_IDLE;
                        f_d.wr      = 1'b1;
                        f_d.word    = sh_nx;
                    end
                end else begin
                    f_d.cnt = f_q.cnt - CNT_W'(1);
                end
            end
            default: f_d.starter = STARTER_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{starter: STARTER_IDLE, cnt: '0, ring: RING_HOME,
                     shreg: '0, wr: 1'b0, word: '0};
        end else begin
            f_q <= f_d;
        end
    end

    assign wr_o   = f_q.wr;
    assign word_o = f_q.word;

endmodule

// File: rtl/serline_rx_fifo.sv
// Output buffer: show-ahead FIFO with a sticky overflow flag.
module serline_rx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         rd_i,
    output logic [W-1:0] rdata_o,
    output logic         empty_o,
    output logic         full_o,
    output logic         ovf_o
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
        logic                    ovf;
    } fifo_t;

    fifo_t b_d, b_q;
    logic  full_w, empty_w, push, pop;

    assign full_w  = (b_q.cnt == CW'(DEPTH));
    assign empty_w = (b_q.cnt == '0);

    always_comb begin
        b_d  = b_q;
        pop  = rd_i && !empty_w;
        push = wr_i && (!full_w || pop);
        if (push) begin
            b_d.mem[b_q.wp] = wdata_i;
            b_d.wp          = b_q.wp + AW'(1);
        end
        if (pop) begin
            b_d.rp = b_q.rp + AW'(1);
        end
        case ({push, pop})
            2'b10:   b_d.cnt = b_q.cnt + CW'(1);
            2'b01:   b_d.cnt = b_q.cnt - CW'(1);
            default: b_d.cnt = b_q.cnt;
        endcase
        if (wr_i && full_w && !rd_i) begin
            b_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign rdata_o = b_q.mem[b_q.rp];
    assign empty_o = empty_w;
    assign full_o  = full_w;
    assign ovf_o   = b_q.ovf;

endmodule

// File: rtl/serline_rx.sv
// Single-wire start-bit serial receiver, top level.
module serline_rx #(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              empty_o,
    output logic              full_o,
    output logic              wr_pulse_o,
    output logic              ovf_o
);

    logic              line_s;
    logic              rise;
    logic              wr;
    logic [DATA_W-1:0] word;

    serline_rx_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (line_i),
        .line_s_o (line_s),
        .rise_o   (rise)
    );

    serline_rx_frame #(
        .DATA_W (DATA_W),
        .OSR    (OSR)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_s_i (line_s),
        .rise_i   (rise),
        .wr_o     (wr),
        .word_o   (word)
    );

    serline_rx_fifo #(
        .W     (DATA_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr),
        .wdata_i (word),
        .rd_i    (rd_i),
        .rdata_o (rd_data_o),
        .empty_o (empty_o),
        .full_o  (full_o),
        .ovf_o   (ovf_o)
    );

    assign wr_pulse_o = wr;

endmodule

// File: rtl/serline_rx_chk.sv
// Port-level properties of the receiver, attached with bind.
module serline_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_i,
    input logic empty_o,
    input logic full_o,
    input logic wr_pulse_o,
    input logic ovf_o
);

    // R5: the write pulse never lasts two cycles
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse_o |=> !wr_pulse_o);

    // R8: full and empty never together
    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));

    // R8: a word written into an empty buffer makes it non-empty
    p_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && wr_pulse_o) |=> !empty_o);

    // R9: overflow is sticky
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    // R9: overflow rises only after a write into a full buffer without a pop
    p_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> $past(full_o && wr_pulse_o && !rd_i));

    // R10: write and pop together on a full buffer keep it full, flag unchanged
    p_full_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && wr_pulse_o && rd_i) |=> (full_o && $stable(ovf_o)));

    // R11: popping an empty buffer leaves it empty
    p_empty_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && !wr_pulse_o) |=> empty_o);

endmodule

bind serline_rx serline_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_i       (rd_i),
    .empty_o    (empty_o),
    .full_o     (full_o),
    .wr_pulse_o (wr_pulse_o),
    .ovf_o      (ovf_o)
);

// File: tb/serline_rx_test.sv
`timescale 1ns/1ps
module serline_rx_test;

    localparam int DATA_W = 8;
    localparam int OSR    = 16;
    localparam int DEPTH  = 16;
    localparam real BIT_NOM  = 64.0;   // OSR x 4 ns
    localparam real BIT_FAST = 60.8;   // -5 %
    localparam real BIT_SLOW = 67.2;   // +5 %

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              line = 1'b0;
    logic              rd = 1'b0;
    logic [DATA_W-1:0] rd_data_o;
    logic              empty_o, full_o, wr_pulse_o, ovf_o;

    int n_chk = 0;
    int n_fail = 0;
    int pulses = 0;
    int exp_q[$];

    always #2 clk = ~clk;

    serline_rx #(.DATA_W(DATA_W), .OSR(OSR), .DEPTH(DEPTH), .SYNC_STAGES(2)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line),
        .rd_i       (rd),
        .rd_data_o  (rd_data_o),
        .empty_o    (empty_o),
        .full_o     (full_o),
        .wr_pulse_o (wr_pulse_o),
        .ovf_o      (ovf_o)
    );

    always @(negedge clk) begin
        if (rst_n && wr_pulse_o) pulses = pulses + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // start bit, data LSB first, stop bit, then optional idle
    task automatic send_frame(input logic [7:0] w, input real bit_ns, input real gap_ns);
        line = 1'b1;
        #(bit_ns);
        for (int b = 0; b < DATA_W; b++) begin
            line = w[b];
            #(bit_ns);
        end
        line = 1'b0;
        #(bit_ns);
        if (gap_ns > 0.0) #(gap_ns);
    endtask

    task automatic drain(input string tag);
        int e;
        @(negedge clk);
        while (!empty_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, tag, int'(rd_data_o), -1);
            end else begin
                e = exp_q.pop_front();
                check(int'(rd_data_o) == e, tag, int'(rd_data_o), e);
            end
            rd = 1'b1;
            @(negedge clk);
            rd = 1'b0;
            @(negedge clk);
        end
        check(exp_q.size() == 0, tag, 0, exp_q.size());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        int p0;
        real bp;
        real gap;
        logic [7:0] w;

        repeat (4) @(negedge clk);
        // R1 during reset
        check(empty_o == 1'b1, "R1 empty in reset", int'(empty_o), 1);
        check(ovf_o == 1'b0, "R1 ovf in reset", int'(ovf_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(empty_o == 1'b1, "R1 empty", int'(empty_o), 1);
        check(full_o == 1'b0, "R1 full", int'(full_o), 0);
        check(ovf_o == 1'b0, "R1 ovf", int'(ovf_o), 0);
        check(wr_pulse_o == 1'b0, "R1 pulse", int'(wr_pulse_o), 0);

        // R2: one rising edge, then a long high level
        #1.3;
        line = 1'b1;
        #(BIT_NOM * 30.0);
        line = 1'b0;
        #(BIT_NOM * 2.0);
        check(pulses == 1, "R2 word count", pulses, 1);
        exp_q.push_back(8'hFF);
        drain("R2");

        // R3 R4 R6 R7: every byte value, three bit rates, with and without gaps
        p0 = pulses;
        for (int i = 0; i < 256; i++) begin
            case (i % 3)
                0:       bp = BIT_NOM;
                1:       bp = BIT_FAST;
                default: bp = BIT_SLOW;
            endcase
            gap = (i % 4 == 0) ? 0.0 : 3.7 + 5.3 * real'(i % 7);
            w = 8'(i);
            send_frame(w, bp, gap);
            exp_q.push_back(int'(w));
            if ((i % 12) == 11 || i == 255) drain("R3 R4 R6 sweep");
        end
        check(pulses - p0 == 256, "R5 R7 one pulse per frame", pulses - p0, 256);

        // R8: fill the buffer
        for (int k = 0; k < DEPTH; k++) begin
            w = 8'((k * 37 + 5) % 256);
            send_frame(w, BIT_NOM, 10.0);
            exp_q.push_back(int'(w));
        end
        check(full_o == 1'b1, "R8 full", int'(full_o), 1);
        check(empty_o == 1'b0, "R8 not empty", int'(empty_o), 0);
        check(ovf_o == 1'b0, "R8 no ovf", int'(ovf_o), 0);

        // R10: push and pop on the same edge while full
        fork
            send_frame(8'hC3, BIT_FAST, 10.0);
            begin
                @(negedge clk);
                while (!wr_pulse_o) @(negedge clk);
                check(int'(rd_data_o) == exp_q[0], "R10 head before pop",
                      int'(rd_data_o), exp_q[0]);
                rd = 1'b1;
                @(negedge clk);
                rd = 1'b0;
            end
        join
        void'(exp_q.pop_front());
        exp_q.push_back(8'hC3);
        @(negedge clk);
        check(full_o == 1'b1, "R10 still full", int'(full_o), 1);
        check(ovf_o == 1'b0, "R10 no ovf", int'(ovf_o), 0);
        check(int'(rd_data_o) == exp_q[0], "R10 new head", int'(rd_data_o), exp_q[0]);

        // R9: write into a full buffer without a pop
        send_frame(8'h3C, BIT_SLOW, 10.0);
        check(ovf_o == 1'b1, "R9 ovf set", int'(ovf_o), 1);
        check(full_o == 1'b1, "R9 still full", int'(full_o), 1);
        drain("R8 R9 order after drop");
        check(ovf_o == 1'b1, "R9 sticky", int'(ovf_o), 1);

        // R11: pops on an empty buffer
        @(negedge clk);
        rd = 1'b1;
        repeat (5) @(negedge clk);
        rd = 1'b0;
        @(negedge clk);
        check(empty_o == 1'b1, "R11 still empty", int'(empty_o), 1);
        check(full_o == 1'b0, "R11 not full", int'(full_o), 0);
        send_frame(8'h5A, BIT_NOM, 10.0);
        exp_q.push_back(8'h5A);
        drain("R11 word after empty pops");

        summary();
    end

endmodule